// File: doc/BRIEF.md
# ALU Condition Flag Register

This block is the eight-bit processor status register that sits beside an integer ALU. Each cycle it can take the operands and the result of one ALU operation, together with an operation class. From these it derives carry, zero, negative, two's-complement overflow, sign and half-carry, and it stores the ones that class updates. The same register also holds two control bits. One is the global interrupt enable. The other is a one-bit scratch flag that moves a single bit between general registers.

The interrupt controller drives the enable bit: it clears the bit when an interrupt is taken, and a return from interrupt sets it again. The instruction decoder sets or clears the bit with explicit commands. The decoder also issues bit-store commands, which load the scratch flag from a selected bit of a register. For a bit-load, the block returns a register value with the selected bit replaced by the scratch flag. Software can write the whole register directly, and that write wins over every other update in the same cycle. Nothing is saved or restored when an interrupt is entered or left.

Top module: `alu_flag_reg`

## Requirements
- R1: A synchronous active-high reset clears all eight flag bits. The bit layout is I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R2: The stored S bit always equals N xor V. This holds after a direct write as well: bit 4 of the write data is ignored and S is derived from the written N and V.
- R3: Operation class 0 is addition. When alu_valid is high with this class, C is the carry out of the top bit and H is the carry out of bit 3. V is set when both operands have the same sign and the result sign differs. N is the result MSB, and Z is set when the result is zero. A carry-in already folded into the result is handled correctly.
- R4: Operation class 1 is subtraction (a minus b, with an optional borrow-in folded into the result). C and H are the borrow out of the top bit and out of bit 3. V is set when the operands differ in sign and the result sign differs from a. N and Z follow the result.
- R5: Operation class 2 is logical. It clears V and updates N and Z from the result. C and H keep their values.
- R6: irq_take clears I. irq_return sets I. Neither changes any other bit.
- R7: ie_set sets I and ie_clr clears I. When commands collide in one cycle, a clear (irq_take or ie_clr) beats a set (irq_return or ie_set).
- R8: bst_en loads T with bit bst_sel of bst_src.
- R9: bld_out equals bld_src with bit bld_sel replaced by the current stored T. It is combinational.
- R10: wr_en loads the register from wr_data (with S per R2) and overrides every other update in the same cycle.
- R11: Interrupt entry and return do not save, restore or alter C, Z, N, V, S, H or T.
- R12: With alu_valid low, or with operation class 3, the arithmetic flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | An ALU result is present this cycle |
| alu_op | input | 2 | Operation class: 0 add, 1 subtract, 2 logical, 3 no flag update |
| alu_a | input | DATA_W | First operand |
| alu_b | input | DATA_W | Second operand |
| alu_res | input | DATA_W | ALU result |
| irq_take | input | 1 | Interrupt taken, clear I |
| irq_return | input | 1 | Return from interrupt, set I |
| ie_set | input | 1 | Explicit enable command |
| ie_clr | input | 1 | Explicit disable command |
| bst_en | input | 1 | Bit-store into T |
| bst_src | input | DATA_W | Register value for bit-store |
| bst_sel | input | SEL_W | Bit index for bit-store |
| bld_src | input | DATA_W | Register value for bit-load |
| bld_sel | input | SEL_W | Bit index for bit-load |
| bld_out | output | DATA_W | bld_src with the selected bit replaced by T |
| wr_en | input | 1 | Direct register write |
| wr_data | input | 8 | Direct write value |
| flags | output | 8 | Stored flag register |

## Verification
The bench builds the block with its default DATA_W of 8. This gives a half-carry position of bit 3 and a three-bit selector, so every bit index of the bit-store and bit-load paths is reachable. The 8-bit sign boundaries 0x7F/0x80 and the wrap at 0xFF/0x00 can be driven directly, and directed cases hit carry, borrow, overflow and half-carry at those edges. Random runs add collisions between enable commands, bit stores, ALU updates and direct writes in the same cycle.

// File: rtl/flagreg_pkg.sv
`timescale 1ns/1ps
package flagreg_pkg;

    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_N = 2;
    localparam int FB_V = 3;
    localparam int FB_S = 4;
    localparam int FB_H = 5;
    localparam int FB_T = 6;
    localparam int FB_I = 7;
    localparam int FLAG_W = 8;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_LOGIC = 2'd2,
        OPC_NONE  = 2'd3
    } opclass_e;

    typedef struct packed {
        logic upd_ch;
        logic upd_nzv;
        logic c;
        logic z;
        logic n;
        logic v;
        logic h;
    } alu_flags_t;

    function automatic logic add_carry(input logic a, input logic b, input logic r);
        return (a & b) | (a & ~r) | (b & ~r);
    endfunction

    function automatic logic sub_borrow(input logic a, input logic b, input logic r);
        return (~a & b) | (b & r) | (r & ~a);
    endfunction

endpackage

// File: rtl/flagreg_calc.sv
`timescale 1ns/1ps
module flagreg_calc
    import flagreg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              valid,
    input  opclass_e          op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] res,
    output alu_flags_t        flg
);
    localparam int MSB      = DATA_W - 1;
    localparam int HALF_BIT = DATA_W / 2 - 1;

    logic unused_ab;
    assign unused_ab = ^{a, b};

    always_comb begin
        flg         = '0;
        flg.n       = res[MSB];
        flg.z       = (res == '0);
        if (valid) begin
            unique case (op)
                OPC_ADD: begin
                    flg.upd_ch  = 1'b1;
                    flg.upd_nzv = 1'b1;
                    flg.c = add_carry(a[MSB], b[MSB], res[MSB]);
                    flg.h = add_carry(a[HALF_BIT], b[HALF_BIT], res[HALF_BIT]);
                    flg.v = (a[MSB] & b[MSB] & ~res[MSB]) | (~a[MSB] & ~b[MSB] & res[MSB]);
                end
                OPC_SUB: begin
                    flg.upd_ch  = 1'b1;
                    flg.upd_nzv = 1'b1;
                    flg.c = sub_borrow(a[MSB], b[MSB], res[MSB]);
                    flg.h = sub_borrow(a[HALF_BIT], b[HALF_BIT], res[HALF_BIT]);
                    flg.v = (a[MSB] & ~b[MSB] & ~res[MSB]) | (~a[MSB] & b[MSB] & res[MSB]);
                end
                OPC_LOGIC: begin
                    flg.upd_nzv = 1'b1;
                    flg.v       = 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/flagreg_bitcopy.sv
`timescale 1ns/1ps
module flagreg_bitcopy #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] bst_src,
    input  logic [SEL_W-1:0]  bst_sel,
    output logic              bst_bit,
    input  logic [DATA_W-1:0] bld_src,
    input  logic [SEL_W-1:0]  bld_sel,
    input  logic              t_bit,
    output logic [DATA_W-1:0] bld_out
);
    assign bst_bit = bst_src[bst_sel];

    for (genvar k = 0; k < DATA_W; k++) begin : g_bld
        assign bld_out[k] = (bld_sel == SEL_W'(k)) ? t_bit : bld_src[k];
    end

endmodule

// File: rtl/flagreg_ie.sv
`timescale 1ns/1ps
module flagreg_ie (
    input  logic i_cur,
    input  logic irq_take,
    input  logic irq_return,
    input  logic ie_set,
    input  logic ie_clr,
    output logic i_nxt
);
    always_comb begin
        if (irq_take || ie_clr)
            i_nxt = 1'b0;
        else if (irq_return || ie_set)
            i_nxt = 1'b1;
        else
            i_nxt = i_cur;
    end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg
    import flagreg_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_valid,
    input  logic [1:0]        alu_op,
    input  logic [DATA_W-1:0] alu_a,
    input  logic [DATA_W-1:0] alu_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              irq_take,
    input  logic              irq_return,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              bst_en,
    input  logic [DATA_W-1:0] bst_src,
    input  logic [SEL_W-1:0]  bst_sel,
    input  logic [DATA_W-1:0] bld_src,
    input  logic [SEL_W-1:0]  bld_sel,
    output logic [DATA_W-1:0] bld_out,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] q, q_nxt;
    alu_flags_t        calc;
    logic              bst_bit;
    logic              i_nxt;

    flagreg_calc #(.DATA_W(DATA_W)) u_calc (
        .valid (alu_valid),
        .op    (opclass_e'(alu_op)),
        .a     (alu_a),
        .b     (alu_b),
        .res   (alu_res),
        .flg   (calc)
    );

    flagreg_bitcopy #(.DATA_W(DATA_W)) u_bitcopy (
        .bst_src (bst_src),
        .bst_sel (bst_sel),
        .bst_bit (bst_bit),
        .bld_src (bld_src),
        .bld_sel (bld_sel),
        .t_bit   (q[FB_T]),
        .bld_out (bld_out)
    );

    flagreg_ie u_ie (
        .i_cur      (q[FB_I]),
        .irq_take   (irq_take),
        .irq_return (irq_return),
        .ie_set     (ie_set),
        .ie_clr     (ie_clr),
        .i_nxt      (i_nxt)
    );

    always_comb begin
        q_nxt = q;
        if (calc.upd_nzv) begin
            q_nxt[FB_N] = calc.n;
            q_nxt[FB_Z] = calc.z;
            q_nxt[FB_V] = calc.v;
        end
        if (calc.upd_ch) begin
            q_nxt[FB_C] = calc.c;
            q_nxt[FB_H] = calc.h;
        end
        if (bst_en)
            q_nxt[FB_T] = bst_bit;
        q_nxt[FB_I] = i_nxt;
        q_nxt[FB_S] = q_nxt[FB_N] ^ q_nxt[FB_V];
        if (wr_en) begin
            q_nxt       = wr_data;
            q_nxt[FB_S] = wr_data[FB_N] ^ wr_data[FB_V];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_nxt;
    end

    assign flags = q;

    AST_SIGN_RELATION: assert property (@(posedge clk) disable iff (rst)
        flags[FB_S] == (flags[FB_N] ^ flags[FB_V])); // R2

    AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && alu_op == 2'd2 && !wr_en) |=>
            (flags[FB_C] == $past(flags[FB_C]) && flags[FB_H] == $past(flags[FB_H]) && !flags[FB_V])); // R5

    AST_TAKE_CLEARS_I: assert property (@(posedge clk) disable iff (rst)
        ((irq_take || ie_clr) && !wr_en) |=> !flags[FB_I]); // R7

    AST_RETURN_SETS_I: assert property (@(posedge clk) disable iff (rst)
        (irq_return && !irq_take && !ie_clr && !wr_en) |=> flags[FB_I]); // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (flags[7:5] == $past(wr_data[7:5]) && flags[3:0] == $past(wr_data[3:0]))); // R10

    AST_IRQ_KEEPS_REST: assert property (@(posedge clk) disable iff (rst)
        (!alu_valid && !bst_en && !wr_en) |=> $stable(flags[FB_T:FB_C])); // R11

endmodule

// File: tb/test_alu_flag_reg.sv
`timescale 1ns/1ps
module test_alu_flag_reg;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       alu_valid;
    logic [1:0] alu_op;
    logic [W-1:0] alu_a, alu_b, alu_res;
    logic       irq_take, irq_return, ie_set, ie_clr;
    logic       bst_en;
    logic [W-1:0] bst_src, bld_src, bld_out;
    logic [2:0] bst_sel, bld_sel;
    logic       wr_en;
    logic [7:0] wr_data, flags;

    logic       s_ci;
    logic [7:0] exp_q;
    string      exp_tag;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;

    alu_flag_reg i_alu_flag_reg (
        .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_op(alu_op),
        .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res),
        .irq_take(irq_take), .irq_return(irq_return), .ie_set(ie_set), .ie_clr(ie_clr),
        .bst_en(bst_en), .bst_src(bst_src), .bst_sel(bst_sel),
        .bld_src(bld_src), .bld_sel(bld_sel), .bld_out(bld_out),
        .wr_en(wr_en), .wr_data(wr_data), .flags(flags)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] cur);
        logic [7:0] n = cur;
        int sa, sb, sd, ci;
        sa = int'($signed(alu_a));
        sb = int'($signed(alu_b));
        ci = int'(s_ci);
        if (alu_valid && alu_op != 2'd3) begin
            n[2] = alu_res[7];
            n[1] = (alu_res == 8'h00);
            if (alu_op == 2'd0) begin
                n[0] = (int'(alu_a) + int'(alu_b) + ci) > 255;
                n[5] = (int'(alu_a[3:0]) + int'(alu_b[3:0]) + ci) > 15;
                sd = sa + sb + ci;
                n[3] = (sd > 127) || (sd < -128);
            end else if (alu_op == 2'd1) begin
                n[0] = int'(alu_a) < int'(alu_b) + ci;
                n[5] = int'(alu_a[3:0]) < int'(alu_b[3:0]) + ci;
                sd = sa - sb - ci;
                n[3] = (sd > 127) || (sd < -128);
            end else begin
                n[3] = 1'b0;
            end
        end
        if (bst_en) n[6] = bst_src[bst_sel];
        if (irq_take || ie_clr) n[7] = 1'b0;
        else if (irq_return || ie_set) n[7] = 1'b1;
        n[4] = n[2] ^ n[3];
        if (wr_en) begin
            n = wr_data;
            n[4] = wr_data[2] ^ wr_data[3];
        end
        return n;
    endfunction

    function automatic string pick_tag();
        if (wr_en) return "R10";
        if (alu_valid) begin
            case (alu_op)
                2'd0: return "R3";
                2'd1: return "R4";
                2'd2: return "R5";
                default: return "R12";
            endcase
        end
        if (irq_take || irq_return) return "R11";
        if (bst_en) return "R8";
        if (ie_set || ie_clr) return "R7";
        return "R12";
    endfunction

    task automatic clear_stim();
        alu_valid = 0; alu_op = 0; alu_a = 0; alu_b = 0; alu_res = 0; s_ci = 0;
        irq_take = 0; irq_return = 0; ie_set = 0; ie_clr = 0;
        bst_en = 0; bst_src = 0; bst_sel = 0; bld_src = 0; bld_sel = 0;
        wr_en = 0; wr_data = 0;
    endtask

    task automatic set_alu(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b, input logic ci);
        alu_valid = 1; alu_op = op; alu_a = a; alu_b = b; s_ci = ci;
        case (op)
            2'd0: alu_res = 8'(a + b + 8'(ci));
            2'd1: alu_res = 8'(a - b - 8'(ci));
            default: alu_res = a & b;
        endcase
    endtask

    task automatic rand_stim();
        clear_stim();
        if ($urandom_range(0, 3) != 0) begin
            set_alu(2'($urandom_range(0, 3)), 8'($urandom), 8'($urandom), 1'($urandom));
            if (alu_op == 2'd2 && $urandom_range(0, 1) == 1) alu_res = 8'($urandom) & 8'hF0;
            if (alu_op == 2'd3) alu_res = 8'($urandom);
        end
        irq_take   = ($urandom_range(0, 7) == 0);
        irq_return = ($urandom_range(0, 5) == 0);
        ie_set     = ($urandom_range(0, 5) == 0);
        ie_clr     = ($urandom_range(0, 7) == 0);
        bst_en     = ($urandom_range(0, 3) == 0);
        bst_src    = 8'($urandom);
        bst_sel    = 3'($urandom);
        bld_src    = 8'($urandom);
        bld_sel    = 3'($urandom);
        wr_en      = ($urandom_range(0, 15) == 0);
        wr_data    = 8'($urandom);
    endtask

    // Apply the current stimulus for one clock and check the result at the next falling edge.
    task automatic step();
        logic [7:0] bld_exp;
        #1;
        bld_exp = bld_src;
        bld_exp[bld_sel] = exp_q[6];
        chk("R9 bit-load output", bld_out, bld_exp);
        exp_tag = pick_tag();
        exp_q   = model(exp_q);
        @(negedge clk);
        chk(exp_tag, flags, exp_q);
        chk("R2 sign bit", {7'd0, flags[4]}, {7'd0, flags[2] ^ flags[3]});
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        clear_stim();
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 reset value", flags, 8'h00);
        rst = 0;
        exp_q = 8'h00;

        set_alu(2'd0, 8'h0F, 8'h01, 0); step();               // R3 half carry
        clear_stim(); set_alu(2'd0, 8'h7F, 8'h01, 0); step(); // R3 overflow
        clear_stim(); set_alu(2'd0, 8'hFF, 8'h01, 0); step(); // R3 carry and zero
        clear_stim(); set_alu(2'd0, 8'hFE, 8'h01, 1); step(); // R3 carry-in
        clear_stim(); set_alu(2'd1, 8'h00, 8'h01, 0); step(); // R4 borrow
        clear_stim(); set_alu(2'd1, 8'h80, 8'h01, 0); step(); // R4 overflow
        clear_stim(); set_alu(2'd0, 8'hF0, 8'h20, 0); step(); // set C before logic
        clear_stim(); set_alu(2'd2, 8'hF0, 8'h0F, 0); step(); // R5 keeps C
        clear_stim(); alu_valid = 1; alu_op = 2'd3; alu_res = 8'h00; step(); // R12
        clear_stim(); ie_set = 1; ie_clr = 1; step();          // R7 clear wins
        clear_stim(); ie_set = 1; step();                      // R7
        clear_stim(); irq_take = 1; irq_return = 1; step();    // R6 take wins
        clear_stim(); irq_return = 1; step();                  // R6 R11
        clear_stim(); irq_take = 1; step();                    // R6 R11
        clear_stim(); bst_en = 1; bst_src = 8'h80; bst_sel = 3'd7; bld_sel = 3'd0; step(); // R8
        clear_stim(); bld_src = 8'h00; bld_sel = 3'd5; step(); // R9 with T=1
        clear_stim(); wr_en = 1; wr_data = 8'h10; set_alu(2'd0, 8'hFF, 8'h01, 0);
        ie_set = 1; bst_en = 1; bst_src = 8'hFF; step();       // R10 write wins, S ignored
        clear_stim(); wr_en = 1; wr_data = 8'h08; step();      // R2 S from V
        clear_stim(); wr_en = 1; wr_data = 8'hEF; step();      // R10

        for (int i = 0; i < 4000; i++) begin
            rand_stim();
            step();
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule